// File: doc/BRIEF.md
# Packed Signed 16-bit Multiplier with Pairwise Accumulate

The block takes two 64-bit operands and treats each as four signed 16-bit lanes. Each lane of the first operand is multiplied by the same lane of the second operand. This gives four signed 32-bit products from a single multiplier array. A 2-bit mode input, sampled together with the operands, selects how the products are returned. The first option keeps the lower half of every product in its own lane. The second keeps the upper half of every product in its own lane. The third adds neighbouring products to form two 32-bit lanes.

Operations enter on a single-cycle valid strobe and emerge exactly two clock cycles later. One operation can be accepted on every cycle. The unit never stalls, so a producer may stream operands back to back. Between operations the output data holds the last result.

Top module: `pmul_unit`

## Requirements
- R1: While reset is asserted (rst_n low) and on the first cycle after it is released, out_valid is 0 and result is all zeros.
- R2: out_valid is high in exactly those cycles that come two rising clock edges after a cycle in which in_valid was high. The result for that operation is presented in the same cycle.
- R3: Operations presented on consecutive cycles each produce their own correct result, on consecutive cycles and in order, with no stall.
- R4: Mode 0 (low half): result bits [16i+15:16i] hold bits [15:0] of the signed product of lane i of a and lane i of b, for i = 0..3.
- R5: Mode 1 (high half): result bits [16i+15:16i] hold bits [31:16] of the signed product of lane i of a and lane i of b.
- R6: Mode 2 (pair sum): result[31:0] is the sum of the lane 0 and lane 1 products, and result[63:32] is the sum of the lane 2 and lane 3 products. Each sum is taken modulo 2^32, so when every lane is -32768 each half is 0x80000000.
- R7: All lanes are multiplied as signed two's-complement values. For example, -1 times -1 gives a low half of 0x0001 and a high half of 0x0000, and -1 times 1 gives 0xFFFF in both halves.
- R8: Mode 3 returns the same result as mode 0.
- R9: When no operation completes in a cycle, result keeps its previous value, whatever a, b and mode are doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | 0 low half, 1 high half, 2 pair sum, 3 same as 0 |
| a | input | 64 | First operand, four signed 16-bit lanes, lane 0 in bits [15:0] |
| b | input | 64 | Second operand, same lane layout |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 64 | Selected result |

## Verification
The checker assumes that rst_n is held low from time zero for at least one clock edge. It also assumes that mode, a and b are at known values on every cycle in which in_valid is high, because the data properties evaluate the operands two cycles later through $past. The stimulus applies reset at time zero and keeps every input driven to a defined value at all times. It changes inputs only on falling edges and, in the hold scenario, keeps scrambling a, b and mode while in_valid is low.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    typedef enum logic [1:0] {
        MODE_LOW  = 2'd0,
        MODE_HIGH = 2'd1,
        MODE_PAIR = 2'd2,
        MODE_ALT  = 2'd3
    } mode_e;

endpackage

// File: rtl/pmul_lane_mult.sv
module pmul_lane_mult #(
    parameter int W = 16
) (
    input  logic signed [W-1:0]   a_i,
    input  logic signed [W-1:0]   b_i,
    output logic signed [2*W-1:0] p_o
);

    assign p_o = a_i * b_i;

endmodule

// File: rtl/pmul_combine.sv
module pmul_combine #(
    parameter int LANE_W = 16,
    parameter int LANES  = 4,
    localparam int PROD_W = 2 * LANE_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  pmul_pkg::mode_e            mode_i,
    input  logic [LANES*PROD_W-1:0]    prod_i,
    output logic [DATA_W-1:0]          res_o
);
    import pmul_pkg::*;

    always_comb begin
        res_o = '0;
        case (mode_i)
            MODE_HIGH: begin
                for (int i = 0; i < LANES; i++) begin
                    res_o[i*LANE_W +: LANE_W] = prod_i[i*PROD_W+LANE_W +: LANE_W];
                end
            end
            MODE_PAIR: begin
                for (int j = 0; j < LANES/2; j++) begin
                    res_o[j*PROD_W +: PROD_W] = prod_i[2*j*PROD_W +: PROD_W]
                                              + prod_i[(2*j+1)*PROD_W +: PROD_W];
                end
            end
            default: begin
                for (int i = 0; i < LANES; i++) begin
                    res_o[i*LANE_W +: LANE_W] = prod_i[i*PROD_W +: LANE_W];
                end
            end
        endcase
    end

endmodule

// File: rtl/pmul_unit.sv
module pmul_unit #(
    parameter int LANE_W = 16,
    parameter int LANES  = 4,
    localparam int PROD_W = 2 * LANE_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    import pmul_pkg::*;

    typedef struct packed {
        logic                      s1_v;
        mode_e                     s1_mode;
        logic [LANES*PROD_W-1:0]   s1_prod;
        logic                      s2_v;
        logic [DATA_W-1:0]         s2_res;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [LANES*PROD_W-1:0] prod_w;
    logic [DATA_W-1:0]       comb_res;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pmul_lane_mult #(.W(LANE_W)) u_mult (
            .a_i (a[g*LANE_W +: LANE_W]),
            .b_i (b[g*LANE_W +: LANE_W]),
            .p_o (prod_w[g*PROD_W +: PROD_W])
        );
    end

    pmul_combine #(.LANE_W(LANE_W), .LANES(LANES)) u_combine (
        .mode_i (pipe_q.s1_mode),
        .prod_i (pipe_q.s1_prod),
        .res_o  (comb_res)
    );

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.s1_v    = in_valid;
        if (in_valid) begin
            pipe_d.s1_mode = mode_e'(mode);
            pipe_d.s1_prod = prod_w;
        end
        pipe_d.s2_v    = pipe_q.s1_v;
        if (pipe_q.s1_v) begin
            pipe_d.s2_res = comb_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.s2_v;
    assign result    = pipe_q.s2_res;

endmodule

// File: rtl/pmul_unit_chk.sv
module pmul_unit_chk #(
    parameter int LANE_W = 16,
    parameter int LANES  = 4,
    localparam int DATA_W = LANES * LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        mode,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);

    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (!rst_n) warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    function automatic logic [DATA_W-1:0] expect_of(input logic [1:0] m,
                                                     input logic [DATA_W-1:0] x,
                                                     input logic [DATA_W-1:0] y);
        logic [DATA_W-1:0] r;
        logic signed [2*LANE_W-1:0] p [LANES];
        r = '0;
        for (int i = 0; i < LANES; i++) begin
            p[i] = $signed(x[i*LANE_W +: LANE_W]) * $signed(y[i*LANE_W +: LANE_W]);
        end
        for (int i = 0; i < LANES; i++) begin
            if (m == 2'd1) r[i*LANE_W +: LANE_W] = p[i][2*LANE_W-1:LANE_W];
            else           r[i*LANE_W +: LANE_W] = p[i][LANE_W-1:0];
        end
        if (m == 2'd2) begin
            for (int j = 0; j < LANES/2; j++) begin
                r[j*2*LANE_W +: 2*LANE_W] = p[2*j] + p[2*j+1];
            end
        end
        return r;
    endfunction

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && result == '0));

    p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(result));

    p_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2 && out_valid && $past(mode, 2) == 2'd0)
        |-> result == expect_of(2'd0, $past(a, 2), $past(b, 2)));

    p_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2 && out_valid && $past(mode, 2) == 2'd1)
        |-> result == expect_of(2'd1, $past(a, 2), $past(b, 2)));

    p_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2 && out_valid && $past(mode, 2) == 2'd2)
        |-> result == expect_of(2'd2, $past(a, 2), $past(b, 2)));

    p_alt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2 && out_valid && $past(mode, 2) == 2'd3)
        |-> result == expect_of(2'd0, $past(a, 2), $past(b, 2)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2 && !$past(in_valid, 2)) |-> $stable(result));

endmodule

bind pmul_unit pmul_unit_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_pmul_unit.sv
`timescale 1ns/1ps
module tb_pmul_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    pmul_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .a(a), .b(b), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(input logic [1:0] m,
                                          input logic [63:0] x,
                                          input logic [63:0] y);
        logic [63:0] r;
        logic signed [31:0] p [4];
        for (int i = 0; i < 4; i++) begin
            p[i] = $signed(x[16*i +: 16]) * $signed(y[16*i +: 16]);
        end
        case (m)
            2'd1: r = {p[3][31:16], p[2][31:16], p[1][31:16], p[0][31:16]};
            2'd2: r = {p[2] + p[3], p[0] + p[1]};
            default: r = {p[3][15:0], p[2][15:0], p[1][15:0], p[0][15:0]};
        endcase
        return r;
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // drive one op at a falling edge, return outputs seen two rising edges later
    task automatic run_op(input logic [1:0] m, input logic [63:0] x, input logic [63:0] y,
                          output logic v, output logic [63:0] r);
        @(negedge clk);
        in_valid = 1'b1; mode = m; a = x; b = y;
        @(negedge clk);
        in_valid = 1'b0; a = $urandom; b = $urandom; mode = 2'($urandom);
        @(negedge clk);
        v = out_valid; r = result;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check1("R1 valid in reset", out_valid, 1'b0);
        check64("R1 result in reset", result, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check1("R1 valid after release", out_valid, 1'b0);
        check64("R1 result after release", result, 64'h0);
    endtask

    task automatic test_mode(input string req, input logic [1:0] m,
                             input logic [63:0] x, input logic [63:0] y,
                             input logic [63:0] exp);
        logic v;
        logic [63:0] r;
        run_op(m, x, y, v, r);
        check1({req, " valid"}, v, 1'b1);
        check64(req, r, exp);
    endtask

    task automatic test_signed();
        // lanes 3..0: a = 8000,7FFF,FFFF,FFFF  b = 0002,7FFF,0001,FFFF
        test_mode("R7 signed low", 2'd0, 64'h8000_7FFF_FFFF_FFFF, 64'h0002_7FFF_0001_FFFF,
                  64'h0000_0001_FFFF_0001);
        test_mode("R7 signed high", 2'd1, 64'h8000_7FFF_FFFF_FFFF, 64'h0002_7FFF_0001_FFFF,
                  64'hFFFF_3FFF_FFFF_0000);
    endtask

    task automatic test_pair_wrap();
        test_mode("R6 pair wrap", 2'd2, {4{16'h8000}}, {4{16'h8000}}, 64'h8000_0000_8000_0000);
        test_mode("R6 pair mixed", 2'd2, 64'h0003_FFFE_0100_0007, 64'h0005_0004_FF00_0002,
                  model(2'd2, 64'h0003_FFFE_0100_0007, 64'h0005_0004_FF00_0002));
    endtask

    task automatic test_stream();
        logic [63:0] xs [10];
        logic [63:0] ys [10];
        logic [1:0]  ms [10];
        for (int k = 0; k < 10; k++) begin
            xs[k] = {$urandom, $urandom};
            ys[k] = {$urandom, $urandom};
            ms[k] = 2'(k % 4);
        end
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                check1("R3 stream valid", out_valid, 1'b1);
                check64("R3 stream data", result, model(ms[k-2], xs[k-2], ys[k-2]));
            end
            if (k < 10) begin
                in_valid = 1'b1; mode = ms[k]; a = xs[k]; b = ys[k];
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check1("R2 valid drops after stream", out_valid, 1'b0);
    endtask

    task automatic test_hold();
        logic v;
        logic [63:0] r;
        run_op(2'd1, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, v, r);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check1("R2 no valid when idle", out_valid, 1'b0);
            check64("R9 result holds", result, r);
            a = {$urandom, $urandom}; b = {$urandom, $urandom}; mode = 2'($urandom);
        end
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog R2: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] x1, y1;
        test_reset();
        x1 = 64'h0123_4567_89AB_CDEF;
        y1 = 64'hFEDC_BA98_7654_3210;
        test_mode("R4 low", 2'd0, x1, y1, model(2'd0, x1, y1));
        test_mode("R4 low small", 2'd0, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005,
                  64'h0020_0015_000C_0005);
        test_mode("R5 high", 2'd1, x1, y1, model(2'd1, x1, y1));
        test_mode("R5 high extreme", 2'd1, {4{16'h8000}}, {4{16'h8000}}, {4{16'h4000}});
        test_pair_wrap();
        test_signed();
        test_mode("R8 mode three", 2'd3, x1, y1, model(2'd0, x1, y1));
        test_stream();
        test_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule